// File: doc/BRIEF.md
# Paged IOMMU Address Translator

This block turns the I/O addresses that devices use for DMA into system addresses. It looks each one up in a table of 64-bit translation entries held in on-chip RAM. The table is placed in the I/O address space by a window base, and the page size is a run-time shift. The number of valid entries is also programmable. Each entry carries the target page address in its upper bits and a two-bit access permission in its lowest bits. A request carries an I/O address and an access type (read or write). The response carries the translated address, the mask that marks the in-page offset, the permission of the entry, and a fault flag.

The configuration comes in as static inputs from the block that owns the table, and that block also writes entries through a simple write port. While the table is disabled the effective configuration reads back as zero, and every request misses. After reset the table clears itself one entry per cycle. During that sweep no request is accepted. Requests and responses use valid/ready handshakes. The pipeline accepts one request per cycle and has a fixed latency of two cycles.

Top module: `iommu_xlate`

## Requirements
- R1: The table index is (req_addr - cfg_bus_base) shifted right by cfg_page_shift. The response reflects the entry at that index.
- R2: A request misses if its address is below cfg_bus_base, or if its index is not below cfg_entry_count (or the table depth). A miss returns resp_addr = 0, resp_mask = all ones, resp_perm = 00 and resp_fault = 1.
- R3: On a hit, resp_mask = 2^shift - 1. resp_addr = (entry AND NOT resp_mask) OR ((req_addr - cfg_bus_base) AND resp_mask), so the in-page offset passes through unchanged.
- R4: resp_perm on a hit equals entry bits [1:0]: bit 0 grants read and bit 1 grants write. So 00 is none, 01 is read-only, 10 is write-only and 11 is read-write.
- R5: resp_fault is 1 when the access type (req_write = 0 for read, 1 for write) is not granted by resp_perm. Any response with perm 00 is a fault.
- R6: After reset is released, clear_busy stays high and req_ready stays low until DEPTH clock edges have passed. From then on every entry reads as zero until it is written.
- R7: While cfg_enable is 0, eff_page_shift, eff_entry_count and eff_bus_base are 0 and every request misses as in R2. While cfg_enable is 1, these outputs follow the cfg inputs.
- R8: A request accepted at a clock edge gives resp_valid after the next edge when resp_ready is high. Back-to-back requests are accepted one per cycle.
- R9: While resp_valid is high and resp_ready is low, the response stays stable and no response is lost or reordered.
- R10: An entry written through the tbl_wr port is used by every request accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the table clear sweep |
| cfg_enable | input | 1 | Table enabled |
| cfg_page_shift | input | SHIFT_W | Log2 of the page size |
| cfg_entry_count | input | IDX_W+1 | Number of valid entries |
| cfg_bus_base | input | IOA_W | I/O address where the window starts |
| eff_page_shift | output | SHIFT_W | Effective page shift, 0 when disabled |
| eff_entry_count | output | IDX_W+1 | Effective entry count, 0 when disabled |
| eff_bus_base | output | IOA_W | Effective window base, 0 when disabled |
| tbl_wr_en | input | 1 | Entry write strobe; ignored while clear_busy |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_data | input | 64 | Entry value |
| clear_busy | output | 1 | Reset clear sweep in progress |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | IOA_W | I/O address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_addr | output | 64 | Translated address |
| resp_mask | output | 64 | In-page offset mask |
| resp_perm | output | 2 | Entry permission |
| resp_fault | output | 1 | Access not permitted or miss |

## Verification
Suppose the clear pointer or the busy flag is wrong. Then a request right after reset either sees a stale non-zero entry or is accepted a cycle early, and a fault-free response or an early req_ready shows it on the first lookup. If the pipeline valid bits or the stall hold go wrong, a response is dropped, duplicated or changed while stalled, and the scoreboard sees this on that same response as a queue mismatch or a latency off by one. If the index, the mask or the bounds logic goes wrong, the response for an edge index or an odd offset shows a wrong address or fault.

// File: rtl/iommu_pkg.sv
package iommu_pkg;

    localparam int ENT_W = 64;

    typedef logic [1:0] perm_t;

    localparam perm_t PERM_NONE = 2'b00;
    localparam perm_t PERM_RD   = 2'b01;
    localparam perm_t PERM_WR   = 2'b10;
    localparam perm_t PERM_RW   = 2'b11;

    // Mask keeping the page-number bits of a 64-bit address.
    function automatic logic [ENT_W-1:0] page_mask(input logic [5:0] shift);
        return ~((64'd1 << shift) - 64'd1);
    endfunction

endpackage

// File: rtl/iommu_lookup.sv
module iommu_lookup #(
    parameter int IOA_W   = 40,
    parameter int DEPTH   = 64,
    parameter int SHIFT_W = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic               enable,
    input  logic [IOA_W-1:0]   addr,
    input  logic [IOA_W-1:0]   base,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]   count,
    output logic [IDX_W-1:0]   idx,
    output logic [IOA_W-1:0]   rel,
    output logic               hit
);
    logic [IOA_W-1:0] page_num;
    logic             below;

    always_comb begin
        below    = addr < base;
        rel      = addr - base;
        page_num = rel >> shift;
        idx      = page_num[IDX_W-1:0];
        hit      = enable && !below
                   && (page_num < IOA_W'(count))
                   && (page_num < IOA_W'(DEPTH));
    end

endmodule

// File: rtl/iommu_table.sv
module iommu_table #(
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data,
    output logic             clr_busy
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
    } clr_t;

    clr_t        clr_d, clr_q;
    logic [63:0] mem [DEPTH];
    logic [63:0] rd_q;

    always_comb begin
        clr_d = clr_q;
        if (clr_q.busy) begin
            clr_d.ptr = clr_q.ptr + 1'b1;
            if (clr_q.ptr == IDX_W'(DEPTH - 1)) begin
                clr_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= '{busy: 1'b1, ptr: '0};
        end else begin
            clr_q <= clr_d;
        end
    end

    // Sweep owns the write port until it ends; table writes are dropped meanwhile.
    always_ff @(posedge clk) begin
        if (clr_q.busy) begin
            mem[clr_q.ptr] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem[rd_idx];
        end
    end

    assign rd_data  = rd_q;
    assign clr_busy = clr_q.busy;

    AST_NO_READ_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> !rd_en); // R6

endmodule

// File: rtl/iommu_form.sv
module iommu_form
    import iommu_pkg::*;
#(
    parameter int IOA_W   = 40,
    parameter int SHIFT_W = 6
) (
    input  logic               hit,
    input  logic               write,
    input  logic [IOA_W-1:0]   rel,
    input  logic [ENT_W-1:0]   entry,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ENT_W-1:0]   addr,
    output logic [ENT_W-1:0]   mask,
    output perm_t              perm,
    output logic               fault
);
    logic [ENT_W-1:0] pm;

    always_comb begin
        pm = page_mask(6'(shift));
        if (hit) begin
            addr  = (entry & pm) | (64'(rel) & ~pm);
            mask  = ~pm;
            perm  = entry[1:0];
            fault = write ? !perm[1] : !perm[0];
        end else begin
            addr  = '0;
            mask  = '1;
            perm  = PERM_NONE;
            fault = 1'b1;
        end
    end

endmodule

// File: rtl/iommu_xlate.sv
module iommu_xlate
    import iommu_pkg::*;
#(
    parameter int IOA_W   = 40,
    parameter int DEPTH   = 64,
    parameter int SHIFT_W = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [CNT_W-1:0]   cfg_entry_count,
    input  logic [IOA_W-1:0]   cfg_bus_base,
    output logic [SHIFT_W-1:0] eff_page_shift,
    output logic [CNT_W-1:0]   eff_entry_count,
    output logic [IOA_W-1:0]   eff_bus_base,
    input  logic               tbl_wr_en,
    input  logic [IDX_W-1:0]   tbl_wr_idx,
    input  logic [63:0]        tbl_wr_data,
    output logic               clear_busy,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IOA_W-1:0]   req_addr,
    input  logic               req_write,
    output logic               resp_valid,
    input  logic               resp_ready,
    output logic [63:0]        resp_addr,
    output logic [63:0]        resp_mask,
    output logic [1:0]         resp_perm,
    output logic               resp_fault
);
    typedef struct packed {
        logic             s1_v;
        logic             s1_hit;
        logic             s1_wr;
        logic [IOA_W-1:0] s1_rel;
        logic             s2_v;
        logic [63:0]      s2_addr;
        logic [63:0]      s2_mask;
        perm_t            s2_perm;
        logic             s2_fault;
    } pipe_t;

    pipe_t            d, q;
    logic             advance, accept, rd_en;
    logic [IDX_W-1:0] lk_idx;
    logic [IOA_W-1:0] lk_rel;
    logic             lk_hit;
    logic [63:0]      rd_data;
    logic [63:0]      fm_addr, fm_mask;
    perm_t            fm_perm;
    logic             fm_fault;

    // Effective configuration: all zero while the table is disabled.
    assign eff_page_shift  = cfg_enable ? cfg_page_shift  : '0;
    assign eff_entry_count = cfg_enable ? cfg_entry_count : '0;
    assign eff_bus_base    = cfg_enable ? cfg_bus_base    : '0;

    iommu_lookup #(.IOA_W(IOA_W), .DEPTH(DEPTH), .SHIFT_W(SHIFT_W)) u_lookup (
        .enable (cfg_enable),
        .addr   (req_addr),
        .base   (eff_bus_base),
        .shift  (eff_page_shift),
        .count  (eff_entry_count),
        .idx    (lk_idx),
        .rel    (lk_rel),
        .hit    (lk_hit)
    );

    iommu_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_data  (tbl_wr_data),
        .rd_en    (rd_en),
        .rd_idx   (lk_idx),
        .rd_data  (rd_data),
        .clr_busy (clear_busy)
    );

    iommu_form #(.IOA_W(IOA_W), .SHIFT_W(SHIFT_W)) u_form (
        .hit   (q.s1_hit),
        .write (q.s1_wr),
        .rel   (q.s1_rel),
        .entry (rd_data),
        .shift (eff_page_shift),
        .addr  (fm_addr),
        .mask  (fm_mask),
        .perm  (fm_perm),
        .fault (fm_fault)
    );

    always_comb begin
        advance   = !(q.s2_v && !resp_ready);
        req_ready = advance && !clear_busy;
        accept    = req_valid && req_ready;
        rd_en     = advance && !clear_busy;
        d         = q;
        if (advance) begin
            d.s1_v     = accept;
            d.s1_hit   = lk_hit;
            d.s1_wr    = req_write;
            d.s1_rel   = lk_rel;
            d.s2_v     = q.s1_v;
            d.s2_addr  = fm_addr;
            d.s2_mask  = fm_mask;
            d.s2_perm  = fm_perm;
            d.s2_fault = fm_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign resp_valid = q.s2_v;
    assign resp_addr  = q.s2_addr;
    assign resp_mask  = q.s2_mask;
    assign resp_perm  = q.s2_perm;
    assign resp_fault = q.s2_fault;

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_addr)
            && $stable(resp_mask) && $stable(resp_perm) && $stable(resp_fault)); // R9

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready) && (!resp_valid || resp_ready) |=> resp_valid); // R8

    AST_NONE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_perm == PERM_NONE |-> resp_fault); // R5

    AST_MISS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_mask == '1 |-> resp_addr == '0 && resp_fault); // R2

endmodule

// File: tb/test_iommu_xlate.sv
module test_iommu_xlate;
    localparam int IOA_W = 40;
    localparam int DEPTH = 64;
    localparam int SW    = 6;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_enable;
    logic [SW-1:0]    cfg_page_shift;
    logic [CNT_W-1:0] cfg_entry_count;
    logic [IOA_W-1:0] cfg_bus_base;
    logic [SW-1:0]    eff_page_shift;
    logic [CNT_W-1:0] eff_entry_count;
    logic [IOA_W-1:0] eff_bus_base;
    logic             tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic [63:0]      tbl_wr_data = '0;
    logic             clear_busy;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [IOA_W-1:0] req_addr = '0;
    logic             req_write = 1'b0;
    logic             resp_valid;
    logic             resp_ready;
    logic [63:0]      resp_addr, resp_mask;
    logic [1:0]       resp_perm;
    logic             resp_fault;

    iommu_xlate #(.IOA_W(IOA_W), .DEPTH(DEPTH), .SHIFT_W(SW)) i_iommu_xlate (.*);

    always #10 clk = ~clk;

    typedef struct {
        logic [63:0] a;
        logic [63:0] m;
        logic [1:0]  p;
        logic        f;
        int          acc;
        bit          lat;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model [DEPTH];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          lat_mode = 1'b0;
    bit          prev_stall = 1'b0;
    logic [63:0] h_a, h_m;
    logic [1:0]  h_p;
    logic        h_f;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [IOA_W-1:0] a, input logic wr, input string tag);
        exp_t e;
        logic [IOA_W-1:0] rel, pn;
        logic [63:0] pm, ent;
        bit hit;
        rel = a - cfg_bus_base;
        pn  = rel >> cfg_page_shift;
        hit = cfg_enable && (a >= cfg_bus_base) && (pn < IOA_W'(cfg_entry_count)) && (pn < IOA_W'(DEPTH));
        pm  = ~((64'd1 << cfg_page_shift) - 64'd1);
        e.tag = tag; e.lat = lat_mode; e.acc = 0;
        if (hit) begin
            ent = model[pn[IDX_W-1:0]];
            e.a = (ent & pm) | (64'(rel) & ~pm);
            e.m = ~pm;
            e.p = ent[1:0];
            e.f = wr ? !ent[1] : !ent[0];
        end else begin
            e.a = '0; e.m = '1; e.p = 2'b00; e.f = 1'b1;
        end
        return e;
    endfunction

    task automatic send(input logic [IOA_W-1:0] a, input logic wr, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        while (!req_ready) @(negedge clk);
        e = predict(a, wr, tag);
        e.acc = cyc + 1;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [63:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx); tbl_wr_data = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        model[idx] = v;
    endtask

    // Monitor: scoreboard compare, stall hold and latency.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(resp_valid && resp_addr == h_a && resp_mask == h_m && resp_perm == h_p && resp_fault == h_f,
                    "R9 hold", resp_addr, h_a);
            end
            prev_stall = resp_valid && !resp_ready;
            h_a = resp_addr; h_m = resp_mask; h_p = resp_perm; h_f = resp_fault;
            if (resp_valid && resp_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", resp_addr, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(resp_addr == e.a, {e.tag, " addr"}, resp_addr, e.a);
                    chk(resp_mask == e.m, {e.tag, " mask"}, resp_mask, e.m);
                    chk({resp_perm, resp_fault} == {e.p, e.f}, {e.tag, " perm/fault"},
                        64'({resp_perm, resp_fault}), 64'({e.p, e.f}));
                    if (e.lat) chk(cyc == e.acc + 1, "R8 latency", 64'(cyc), 64'(e.acc + 1));
                end
            end
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        sb.delete();
        repeat (3) @(negedge clk);
        chk(clear_busy == 1'b1, "R6 busy in reset", 64'(clear_busy), 64'd1);
        chk(req_ready == 1'b0, "R6 not ready in reset", 64'(req_ready), 64'd0);
        chk(resp_valid == 1'b0, "R8 no resp in reset", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        begin
            int n;
            n = 0;
            @(negedge clk);
            while (clear_busy) begin
                chk(req_ready == 1'b0, "R6 not ready in sweep", 64'(req_ready), 64'd0);
                n++;
                @(negedge clk);
            end
            chk(n == DEPTH - 1, "R6 sweep length", 64'(n), 64'(DEPTH - 1));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [IOA_W-1:0] BASE = 40'h00_1000_0000;

    initial begin
        rst_n = 1'b0;
        resp_ready = 1'b1;
        cfg_enable = 1'b0;
        cfg_page_shift = 6'd12;
        cfg_entry_count = CNT_W'(16);
        cfg_bus_base = BASE;
        do_reset();

        // Disabled table
        @(negedge clk);
        chk(eff_page_shift == 0, "R7 shift zero", 64'(eff_page_shift), 64'd0);
        chk(eff_entry_count == 0, "R7 count zero", 64'(eff_entry_count), 64'd0);
        chk(eff_bus_base == 0, "R7 base zero", 64'(eff_bus_base), 64'd0);
        send(BASE + 40'h3010, 1'b0, "R7 disabled miss");
        drain();

        cfg_enable = 1'b1;
        @(negedge clk);
        chk(eff_page_shift == 6'd12 && eff_entry_count == CNT_W'(16) && eff_bus_base == BASE,
            "R7 enabled readback", 64'(eff_bus_base), 64'(BASE));
        send(BASE + 40'h5123, 1'b0, "R6 cleared entry");
        drain();

        wr(0, 64'h0000_00AB_CDE0_0FFF);  // rw, junk low bits
        wr(1, 64'h0000_0012_3456_7001);  // read only
        wr(2, 64'h0000_0001_0000_2002);  // write only
        wr(3, 64'h0000_0055_5555_5000);  // none
        wr(15, 64'hFFFF_F000_0000_0003);

        lat_mode = 1'b1;
        send(BASE + 40'h0000, 1'b0, "R4 rw read");
        send(BASE + 40'h0ABC, 1'b1, "R3 rw write offset");
        send(BASE + 40'h1004, 1'b0, "R4 ro read");
        send(BASE + 40'h1FFF, 1'b1, "R5 ro write fault");
        send(BASE + 40'h2008, 1'b0, "R5 wo read fault");
        send(BASE + 40'h2010, 1'b1, "R4 wo write");
        send(BASE + 40'h3000, 1'b0, "R5 none read");
        send(BASE + 40'hFFFF, 1'b0, "R1 last index");
        send(BASE + 40'h10000, 1'b0, "R2 index equals count");
        send(BASE - 40'h1, 1'b0, "R2 below base");
        send(40'hFF_0000_0000, 1'b1, "R2 far above");
        drain();
        lat_mode = 1'b0;

        // Larger pages and shorter table
        cfg_page_shift = 6'd16;
        cfg_entry_count = CNT_W'(4);
        send(BASE + 40'h2_1234, 1'b1, "R1 shift16 index2");
        send(BASE + 40'h3_FFFF, 1'b0, "R3 shift16 offset");
        send(BASE + 40'h4_0000, 1'b0, "R2 shift16 beyond count");
        drain();

        wr(2, 64'h0000_0077_0001_0003);
        send(BASE + 40'h2_0042, 1'b0, "R10 new entry used");
        drain();

        // Backpressure on a burst
        cfg_page_shift = 6'd12;
        cfg_entry_count = CNT_W'(16);
        fork
            begin
                for (int i = 0; i < 8; i++)
                    send(BASE + 40'(i % 4) * 40'h1000 + 40'(i * 8), 1'(i[0]), "R9 burst");
                idle();
            end
            begin
                for (int k = 0; k < 14; k++) begin
                    @(posedge clk);
                    #2 resp_ready = (k % 3 == 2);
                end
                @(posedge clk);
                #2 resp_ready = 1'b1;
            end
        join
        drain();

        // Second reset clears written entries
        do_reset();
        send(BASE + 40'h0040, 1'b0, "R6 clear after reset");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule